// File: doc/BRIEF.md
# Quadrature calibration loop controller

This block is the digital loop that sits behind a quadrature phase corrector for four-phase strobe signals. A pulse-width detector compares one charging interval with the comparator threshold. A counter that runs beside it reduces seven detector samples to a 3-bit tally, and it delivers one tally per cycle of a slow divided clock. The controller turns each tally into a one-bit majority decision. It uses those decisions first to find the current-source code whose charge over a full clock period just reaches the threshold. It then uses them to trim three delay-line codes, so that each adjacent strobe phase spacing equals a quarter period. The I phase runs through a fixed delay and has no code.

Each cycle of `clk_i` with `cal_en_i` high is one decision. After reset the current code is resolved by a binary search. The loop then cycles without end through current-code tracking, the Q delay trim, the IB delay trim and the QB delay trim. Pulling `cal_en_i` low freezes every code and the sequencer position. Raising it again resumes from the point where the loop stopped.

Top module: `qcal_ctrl`

## Requirements
- R1: While `rst_ni` is low, the current code is `1 << (IDAC_W-1)` (32 by default), all three delay codes equal `DLY_INIT` (128), `mode_dqs_o` is 0 and `pair_idx_o` is 0.
- R2: The first IDAC_W enabled decisions after reset form a successive-approximation search, MSB first. A tally of 4 or more clears the bit under trial, and the next lower bit is then set for trial. If the detector reports "high" exactly when the code exceeds a threshold code T, the search ends with the code equal to T.
- R3: After the search, each of TRACK_VOTES decisions moves the current code by one step: down when the tally is 4 or more, up otherwise.
- R4: The order of the loop is search (once only, mode 0), then a repeating pass made of TRACK_VOTES tracking decisions (mode 0, pair 0) followed by DLY_VOTES decisions each on pair 0 (Q), pair 1 (IB) and pair 2 (QB), all in mode 1. `mode_dqs_o` is 1 exactly in the delay phases, and `pair_idx_o` names the code being trimmed.
- R5: A delay decision changes only the code that `pair_idx_o` selects, and by one step: a tally of 4 or more (spacing too long) decrements it, any lower tally increments it.
- R6: The current code does not change in mode 1, and the delay codes do not change in mode 0.
- R7: Every code saturates at 0 and at its all-ones value instead of wrapping.
- R8: While `cal_en_i` is low, no output changes. After it rises, the sequence continues from the position it held when it stopped.
- R9: With an ideal threshold detector in closed loop, each code settles and then stays within one step of its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided decision clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_en_i | input | 1 | Calibration enable; low freezes the loop |
| tally_i | input | 3 | Count of "high" detector samples out of seven |
| idac_code_o | output | IDAC_W | Current-source code |
| dly_q_o | output | DLY_W | Q path delay code |
| dly_ib_o | output | DLY_W | IB path delay code |
| dly_qb_o | output | DLY_W | QB path delay code |
| mode_dqs_o | output | 1 | 0: period measurement, 1: phase-spacing measurement |
| pair_idx_o | output | 2 | Phase pair under trim: 0 Q, 1 IB, 2 QB |

## Verification
A sequencer that slips shows up on the first edge after it happens, because `mode_dqs_o` and `pair_idx_o` are compared on every enabled cycle against a position computed from the count of enabled edges. A wrong decision polarity or a broken search shows in the current code within one decision after the search ends. Wrap-around or a step on the wrong code shows on the next edge as a jump in a delay code larger than one. Frozen state that leaks is caught during the disabled window, and a sequencer that loses its place is caught on the first pass after re-enable.

// File: rtl/qcal_pkg.sv
package qcal_pkg;
  typedef enum logic [1:0] {PH_SAR, PH_TRACK, PH_DQS} phase_e;

  localparam logic [2:0] VOTE_MAJ = 3'd4;

  function automatic logic vote_high(input logic [2:0] tally);
    return tally >= VOTE_MAJ;
  endfunction
endpackage

// File: rtl/qcal_seq.sv
module qcal_seq
  import qcal_pkg::*;
#(
  parameter int IDAC_W      = 6,
  parameter int TRACK_VOTES = 8,
  parameter int DLY_VOTES   = 16,
  parameter int NUM_PAIRS   = 3,
  localparam int MAXV = (IDAC_W > TRACK_VOTES) ?
                        ((IDAC_W > DLY_VOTES) ? IDAC_W : DLY_VOTES) :
                        ((TRACK_VOTES > DLY_VOTES) ? TRACK_VOTES : DLY_VOTES),
  localparam int CW = $clog2(MAXV + 1),
  localparam int PW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic [PW-1:0] pair_o
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pair_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SAR;
      cnt_q   <= CW'(IDAC_W - 1);
      pair_q  <= '0;
    end else if (en_i) begin
      case (phase_q)
        PH_SAR: begin
          if (cnt_q == '0) phase_q <= PH_TRACK;  // cnt already 0 for tracking
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_TRACK: begin
          if (cnt_q == CW'(TRACK_VOTES - 1)) begin
            phase_q <= PH_DQS;
            cnt_q   <= '0;
            pair_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DQS: begin
          if (cnt_q == CW'(DLY_VOTES - 1)) begin
            cnt_q <= '0;
            if (pair_q == PW'(NUM_PAIRS - 1)) begin
              phase_q <= PH_TRACK;
              pair_q  <= '0;
            end else begin
              pair_q <= pair_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_SAR;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign pair_o  = pair_q;
endmodule

// File: rtl/qcal_idac_ctrl.sv
module qcal_idac_ctrl #(
  parameter int IDAC_W = 6,
  parameter int CW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sar_i,
  input  logic              trk_i,
  input  logic [CW-1:0]     bit_i,
  input  logic              hi_i,
  output logic [IDAC_W-1:0] code_o
);
  localparam logic [IDAC_W-1:0] CODE_MAX  = '1;
  localparam logic [IDAC_W-1:0] CODE_INIT = IDAC_W'(1) << (IDAC_W - 1);

  logic [IDAC_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (sar_i) begin
      for (int k = 0; k < IDAC_W; k++) begin
        if (int'(bit_i) == k) begin
          if (hi_i) code_d[k] = 1'b0;
          code_d = code_d | ((IDAC_W'(1) << k) >> 1);  // next trial bit
        end
      end
    end else if (trk_i) begin
      if (hi_i) begin
        if (code_q != '0) code_d = code_q - 1'b1;
      end else if (code_q != CODE_MAX) begin
        code_d = code_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= CODE_INIT;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/qcal_dly_bank.sv
module qcal_dly_bank #(
  parameter int DLY_W     = 8,
  parameter int NUM_PAIRS = 3,
  parameter int DLY_INIT  = 128,
  parameter int PW        = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            act_i,
  input  logic [PW-1:0]                   pair_i,
  input  logic                            hi_i,
  output logic [NUM_PAIRS-1:0][DLY_W-1:0] codes_o
);
  localparam logic [DLY_W-1:0] CODE_MAX = '1;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_line
    logic [DLY_W-1:0] code_q;
    logic             sel;

    assign sel = act_i && (pair_i == PW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        code_q <= DLY_W'(DLY_INIT);
      end else if (sel) begin
        if (hi_i) begin
          if (code_q != '0) code_q <= code_q - 1'b1;   // spacing too long
        end else if (code_q != CODE_MAX) begin
          code_q <= code_q + 1'b1;
        end
      end
    end

    assign codes_o[g] = code_q;
  end
endmodule

// File: rtl/qcal_ctrl.sv
module qcal_ctrl
  import qcal_pkg::*;
#(
  parameter int IDAC_W      = 6,
  parameter int DLY_W       = 8,
  parameter int TRACK_VOTES = 8,
  parameter int DLY_VOTES   = 16,
  parameter int DLY_INIT    = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_en_i,
  input  logic [2:0]        tally_i,
  output logic [IDAC_W-1:0] idac_code_o,
  output logic [DLY_W-1:0]  dly_q_o,
  output logic [DLY_W-1:0]  dly_ib_o,
  output logic [DLY_W-1:0]  dly_qb_o,
  output logic              mode_dqs_o,
  output logic [1:0]        pair_idx_o
);
  localparam int NUM_PAIRS = 3;
  localparam int PW = 2;
  localparam int MAXV = (IDAC_W > TRACK_VOTES) ?
                        ((IDAC_W > DLY_VOTES) ? IDAC_W : DLY_VOTES) :
                        ((TRACK_VOTES > DLY_VOTES) ? TRACK_VOTES : DLY_VOTES);
  localparam int CW = $clog2(MAXV + 1);

  phase_e                          phase;
  logic [CW-1:0]                   cnt;
  logic [PW-1:0]                   pair;
  logic                            hi;
  logic [NUM_PAIRS-1:0][DLY_W-1:0] dly_codes;

  assign hi = vote_high(tally_i);

  qcal_seq #(
    .IDAC_W     (IDAC_W),
    .TRACK_VOTES(TRACK_VOTES),
    .DLY_VOTES  (DLY_VOTES),
    .NUM_PAIRS  (NUM_PAIRS)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cal_en_i),
    .phase_o(phase),
    .cnt_o  (cnt),
    .pair_o (pair)
  );

  qcal_idac_ctrl #(
    .IDAC_W(IDAC_W),
    .CW    (CW)
  ) u_idac (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sar_i (cal_en_i && (phase == PH_SAR)),
    .trk_i (cal_en_i && (phase == PH_TRACK)),
    .bit_i (cnt),
    .hi_i  (hi),
    .code_o(idac_code_o)
  );

  qcal_dly_bank #(
    .DLY_W    (DLY_W),
    .NUM_PAIRS(NUM_PAIRS),
    .DLY_INIT (DLY_INIT),
    .PW       (PW)
  ) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (cal_en_i && (phase == PH_DQS)),
    .pair_i (pair),
    .hi_i   (hi),
    .codes_o(dly_codes)
  );

  assign dly_q_o    = dly_codes[0];
  assign dly_ib_o   = dly_codes[1];
  assign dly_qb_o   = dly_codes[2];
  assign mode_dqs_o = (phase == PH_DQS);
  assign pair_idx_o = pair;
endmodule

// File: rtl/qcal_ctrl_chk.sv
module qcal_ctrl_chk #(
  parameter int IDAC_W = 6,
  parameter int DLY_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cal_en_i,
  input logic [IDAC_W-1:0] idac_code_o,
  input logic [DLY_W-1:0]  dly_q_o,
  input logic [DLY_W-1:0]  dly_ib_o,
  input logic [DLY_W-1:0]  dly_qb_o,
  input logic              mode_dqs_o,
  input logic [1:0]        pair_idx_o
);
  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_en_i |=> ($stable(idac_code_o) && $stable(dly_q_o) && $stable(dly_ib_o)
                   && $stable(dly_qb_o) && $stable(mode_dqs_o) && $stable(pair_idx_o)));

  a_r4_pair_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_idx_o != 2'd3);

  a_r4_pair_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_dqs_o |-> pair_idx_o == 2'd0);

  a_r6_idac_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_dqs_o |=> $stable(idac_code_o));

  a_r6_dly_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_dqs_o |=> ($stable(dly_q_o) && $stable(dly_ib_o) && $stable(dly_qb_o)));

  a_r5_q_only_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_idx_o != 2'd0) |=> $stable(dly_q_o));
  a_r5_ib_only_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_idx_o != 2'd1) |=> $stable(dly_ib_o));
  a_r5_qb_only_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_idx_o != 2'd2) |=> $stable(dly_qb_o));

  // R7: single step in unwrapped arithmetic, so a wrap fails
  a_r7_q_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_en_i |=> (({1'b0, dly_q_o} == {1'b0, $past(dly_q_o)})
               || ({1'b0, dly_q_o} == {1'b0, $past(dly_q_o)} + 1'b1)
               || ({1'b0, $past(dly_q_o)} == {1'b0, dly_q_o} + 1'b1)));
  a_r7_ib_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_en_i |=> (({1'b0, dly_ib_o} == {1'b0, $past(dly_ib_o)})
               || ({1'b0, dly_ib_o} == {1'b0, $past(dly_ib_o)} + 1'b1)
               || ({1'b0, $past(dly_ib_o)} == {1'b0, dly_ib_o} + 1'b1)));
  a_r7_qb_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_en_i |=> (({1'b0, dly_qb_o} == {1'b0, $past(dly_qb_o)})
               || ({1'b0, dly_qb_o} == {1'b0, $past(dly_qb_o)} + 1'b1)
               || ({1'b0, $past(dly_qb_o)} == {1'b0, dly_qb_o} + 1'b1)));
endmodule

bind qcal_ctrl qcal_ctrl_chk #(
  .IDAC_W(IDAC_W),
  .DLY_W (DLY_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cal_en_i   (cal_en_i),
  .idac_code_o(idac_code_o),
  .dly_q_o    (dly_q_o),
  .dly_ib_o   (dly_ib_o),
  .dly_qb_o   (dly_qb_o),
  .mode_dqs_o (mode_dqs_o),
  .pair_idx_o (pair_idx_o)
);

// File: tb/qcal_ctrl_bench.sv
module qcal_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IW   = 6;
  localparam int DW   = 8;
  localparam int TV   = 8;
  localparam int DV   = 16;
  localparam int INIT = 128;
  localparam int PASS = TV + 3 * DV;
  localparam int IMAX = (1 << IW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cal_en = 1'b0;
  logic [2:0]    tally = 3'd0;
  logic [IW-1:0] idac;
  logic [DW-1:0] dq, dib, dqb;
  logic          mode;
  logic [1:0]    pair;

  int checks = 0;
  int errors = 0;
  int n_en = 0;
  int tally_src = 0;     // 0 model, 1 forced low, 2 forced high, 3 random
  int tgt_i = 0;
  int tgt_d[3];
  bit seq_chk = 1'b0;
  int mono_dir = 0;      // +1 non-decreasing, -1 non-increasing
  bit mono_bad = 1'b0;
  int prev[4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  qcal_ctrl #(
    .IDAC_W(IW), .DLY_W(DW), .TRACK_VOTES(TV), .DLY_VOTES(DV), .DLY_INIT(INIT)
  ) u_qcal_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cal_en_i(cal_en), .tally_i(tally),
    .idac_code_o(idac), .dly_q_o(dq), .dly_ib_o(dib), .dly_qb_o(dqb),
    .mode_dqs_o(mode), .pair_idx_o(pair)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int dly_sel(input int p);
    return (p == 0) ? int'(dq) : (p == 1) ? int'(dib) : int'(dqb);
  endfunction

  // expected {mode,pair} after n enabled decisions
  function automatic int exp_pos(input int n);
    int m;
    if (n < IW) return 0;
    m = (n - IW) % PASS;
    if (m < TV) return 0;
    return 4 + (m - TV) / DV;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) n_en <= 0;
    else if (cal_en) n_en <= n_en + 1;

  // behavioural detector model
  always @(negedge clk) begin
    case (tally_src)
      0: if (!mode) tally <= (int'(idac) > tgt_i) ? 3'd7 : 3'd0;
         else       tally <= (dly_sel(int'(pair)) > tgt_d[pair]) ? 3'd7 : 3'd0;
      1: tally <= 3'($urandom_range(0, 3));
      2: tally <= 3'($urandom_range(4, 7));
      default: tally <= 3'($urandom_range(0, 7));
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && seq_chk)
      chk({mode, pair} == 3'(exp_pos(n_en)), "R4", int'({mode, pair}), exp_pos(n_en));
    if (mono_dir > 0 && (int'(idac) < prev[0] || int'(dq) < prev[1] ||
                         int'(dib) < prev[2] || int'(dqb) < prev[3])) mono_bad = 1'b1;
    if (mono_dir < 0 && (int'(idac) > prev[0] || int'(dq) > prev[1] ||
                         int'(dib) > prev[2] || int'(dqb) > prev[3])) mono_bad = 1'b1;
    prev[0] = int'(idac); prev[1] = int'(dq); prev[2] = int'(dib); prev[3] = int'(dqb);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    seq_chk = 1'b0;
    cal_en = 1'b0;
    rst_n = 1'b0;
    cyc(3);
    // R1 reset state
    chk(int'(idac) == (1 << (IW - 1)), "R1 idac", int'(idac), 1 << (IW - 1));
    chk(dq == DW'(INIT) && dib == DW'(INIT) && dqb == DW'(INIT), "R1 dly",
        int'(dq), INIT);
    chk(mode == 1'b0 && pair == 2'd0, "R1 mode", int'({mode, pair}), 0);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic run_round(input int ti, input int t0, input int t1, input int t2,
                           input bit freeze);
    int maxdev;
    tgt_i = ti; tgt_d[0] = t0; tgt_d[1] = t1; tgt_d[2] = t2;
    tally_src = 0;
    do_reset();
    seq_chk = 1'b1;
    cal_en = 1'b1;
    cyc(IW);
    chk(int'(idac) == ti, "R2 search result", int'(idac), ti);
    cyc(1);
    chk(int'(idac) == ((ti < IMAX) ? ti + 1 : IMAX), "R3 first track step",
        int'(idac), (ti < IMAX) ? ti + 1 : IMAX);
    cyc(PASS * 2 + TV + DV + 5);
    if (freeze) begin
      int s[4];
      bit moved = 1'b0;
      s[0] = int'(idac); s[1] = int'(dq); s[2] = int'(dib); s[3] = int'(dqb);
      cal_en = 1'b0;
      tally_src = 3;
      for (int k = 0; k < 25; k++) begin
        cyc(1);
        if (int'(idac) != s[0] || int'(dq) != s[1] || int'(dib) != s[2] ||
            int'(dqb) != s[3] || {mode, pair} != 3'(exp_pos(n_en))) moved = 1'b1;
      end
      chk(!moved, "R8 frozen outputs", int'(moved), 0);
      tally_src = 0;
      cal_en = 1'b1;
    end
    cyc(PASS * 5);
    chk(absd(int'(idac), ti) <= 1, "R9 idac settle", int'(idac), ti);
    chk(absd(int'(dq), t0) <= 1, "R9 q settle", int'(dq), t0);
    chk(absd(int'(dib), t1) <= 1, "R9 ib settle", int'(dib), t1);
    chk(absd(int'(dqb), t2) <= 1, "R9 qb settle", int'(dqb), t2);
    maxdev = 0;
    for (int k = 0; k < PASS * 2; k++) begin
      cyc(1);
      if (absd(int'(idac), ti) > maxdev) maxdev = absd(int'(idac), ti);
      if (absd(int'(dq), t0) > maxdev) maxdev = absd(int'(dq), t0);
      if (absd(int'(dib), t1) > maxdev) maxdev = absd(int'(dib), t1);
      if (absd(int'(dqb), t2) > maxdev) maxdev = absd(int'(dqb), t2);
    end
    chk(maxdev <= 1, "R9 dither", maxdev, 1);
    seq_chk = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5a17));
    prev[0] = 0; prev[1] = 0; prev[2] = 0; prev[3] = 0;
    tgt_d[0] = 0; tgt_d[1] = 0; tgt_d[2] = 0;

    // directed corners: threshold at both ends of the current range
    run_round(0, 90, 128, 170, 1'b0);
    run_round(IMAX, $urandom_range(80, 176), $urandom_range(80, 176),
              $urandom_range(80, 176), 1'b0);
    for (int r = 0; r < 3; r++)
      run_round($urandom_range(1, IMAX - 1), $urandom_range(80, 176),
                $urandom_range(80, 176), $urandom_range(80, 176), r == 1);

    // R5/R7: constant votes drive every code into its rails
    do_reset();
    seq_chk = 1'b1;
    tally_src = 1;
    mono_bad = 1'b0;
    mono_dir = 1;
    cal_en = 1'b1;
    cyc(IW + PASS * 9);
    mono_dir = 0;
    chk(!mono_bad, "R5 low votes only raise", int'(mono_bad), 0);
    chk(int'(idac) == IMAX, "R7 idac top", int'(idac), IMAX);
    chk(int'(dq) == DMAX && int'(dib) == DMAX && int'(dqb) == DMAX, "R7 dly top",
        int'(dqb), DMAX);
    cyc(PASS);
    chk(int'(idac) == IMAX && int'(dq) == DMAX, "R7 hold at top", int'(dq), DMAX);
    tally_src = 2;
    mono_bad = 1'b0;
    mono_dir = -1;
    cyc(PASS * 18);
    mono_dir = 0;
    chk(!mono_bad, "R5 high votes only lower", int'(mono_bad), 0);
    chk(int'(idac) == 0, "R7 idac bottom", int'(idac), 0);
    chk(int'(dq) == 0 && int'(dib) == 0 && int'(dqb) == 0, "R7 dly bottom",
        int'(dib), 0);
    cyc(PASS);
    chk(int'(idac) == 0 && int'(dqb) == 0, "R7 hold at bottom", int'(dqb), 0);
    seq_chk = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R4 act=%0d exp=%0d", n_en, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule